// File: doc/BRIEF.md
# Shutdown and reset sequencing controller

This controller decides when the processor is shut down and drives three outputs: a peripheral reset, a CPU cold reset and a CPU clock stop. Three internal sources can start a shutdown, and two digital battery inputs can too. The first internal source is a restart timer. Software must service it after every CPU restart. The second is an optional deadman counter that software clears periodically. The third is a hibernate request, which is accepted only while no interrupt is pending. A small cause register records why a reset happened. Software clears its bits by writing 1 to them.

The two timers count a slow clock-enable pulse, `tick`. Their limits are parameters, so a short interval can stand in for the seconds-long real one. A reset shutdown holds its outputs for a fixed number of clock cycles and then releases them. Hibernate holds its outputs until an interrupt becomes pending. Either release counts as a CPU restart and re-arms the restart timer. The controller's own state, including the cause bits, is never touched by the resets it issues. Only its own `rst` input clears that state.

Top module: `pwr_seq_ctrl`

## Requirements
- R1: While `rst` is high and on the first sample after it, all three outputs are 0 and `cause` is 0. The restart timer is armed.
- R2: Suppose the restart timer is armed and `rstimer_clr` is not written before the RS_TICKS-th `tick` after a restart. Then `periph_rst` and `cpu_cold_rst` go to 1 in the cycle after that tick, and cause bit 0 (timeout) is set.
- R3: A one-cycle `rstimer_clr` pulse disarms the restart timer. No reset follows from it until the next restart, however many ticks pass.
- R4: While `dm_enable` is 1, DM_TICKS ticks without a `dm_clr` pulse assert `periph_rst` and `cpu_cold_rst` in the cycle after the last of those ticks, and set cause bit 1 (deadman).
- R5: A `dm_clr` pulse restarts the deadman count from zero. While `dm_enable` is 0, the deadman count never expires.
- R6: A `hib_req` with `irq_pending` at 0 sets `cpu_clk_stop` and `periph_rst` to 1 in the next cycle. `cpu_cold_rst` stays 0 and `cause` does not change. Ticks during hibernate start no reset. When `irq_pending` goes to 1, both outputs return to 0 in the next cycle.
- R7: A `hib_req` that arrives while `irq_pending` is 1 is ignored, and all outputs stay 0.
- R8: A `batt_runout` pulse asserts `periph_rst` and `cpu_cold_rst` and sets cause bit 0. A `batt_unlock` pulse asserts the same two outputs and sets no cause bit.
- R9: A reset shutdown keeps `periph_rst` and `cpu_cold_rst` at 1 for exactly HOLD_CYC cycles and then releases them. The release re-arms the restart timer, so it expires again RS_TICKS ticks later.
- R10: With `cause_wr` at 1, each bit set in `cause_wdata` clears the matching cause bit. If a cause event falls in the same cycle, the set wins.
- R11: A reset event and a hibernate request in the same cycle give a reset shutdown: `cpu_cold_rst` goes to 1 and `cpu_clk_stop` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset of the controller itself |
| tick | input | 1 | Slow clock-enable pulse that the timers count |
| rstimer_clr | input | 1 | Software write of 1 that services the restart timer |
| dm_enable | input | 1 | Enables the deadman counter |
| dm_clr | input | 1 | Software write of 1 that restarts the deadman count |
| hib_req | input | 1 | Hibernate request |
| irq_pending | input | 1 | At least one interrupt is pending; also wakes the CPU from hibernate |
| batt_runout | input | 1 | Battery-runout shutdown event |
| batt_unlock | input | 1 | Battery-lock-release shutdown event |
| cause_wr | input | 1 | Write strobe for the cause register |
| cause_wdata | input | 2 | Write-1-to-clear mask; bit 0 is timeout, bit 1 is deadman |
| periph_rst | output | 1 | Reset to all peripherals except the real-time clock and this controller |
| cpu_cold_rst | output | 1 | CPU cold reset |
| cpu_clk_stop | output | 1 | CPU clock stop |
| cause | output | 2 | Shutdown cause bits; bit 0 is timeout, bit 1 is deadman |

## Verification
Every result shows up one clock after the input edge that causes it. That input may be the expiring tick, a battery or hibernate event, a wake interrupt or a cause write. The reason is that the state and the outputs both sit in registers that the same edge updates. The bench drives each input on a falling edge for one cycle. It samples at the next falling edge, which is exactly where that result must first appear. Hold length is checked by sampling on the eighth falling edge after entry, when the outputs must still be high, and again on the ninth, when they must be low. The set-beats-clear case is checked by placing the expiring tick and the clear write in the same cycle.

// File: rtl/pwr_seq_pkg.sv
package pwr_seq_pkg;
  localparam int CAUSE_W       = 2;
  localparam int CAUSE_TIMEOUT = 0;
  localparam int CAUSE_DEADMAN = 1;

  typedef enum logic [1:0] {
    ST_RUN  = 2'd0,
    ST_HOLD = 2'd1,
    ST_HIB  = 2'd2
  } seq_state_t;
endpackage

// File: rtl/pws_tick_window.sv
module pws_tick_window #(
  parameter int LIMIT = 4,
  localparam int CW = (LIMIT > 1) ? $clog2(LIMIT) : 1
) (
  input  logic clk,
  input  logic rst,
  input  logic tick_i,
  input  logic run_i,
  output logic expire_o
);
  logic [CW-1:0] cnt;
  logic          at_end;

  assign at_end   = (32'(cnt) == LIMIT - 1);
  assign expire_o = run_i & tick_i & at_end;

  always_ff @(posedge clk) begin
    if (rst || !run_i) begin
      cnt <= '0;
    end else if (tick_i) begin
      cnt <= at_end ? '0 : cnt + 1'b1;
    end
  end

  // R5: the count restarts from zero whenever the window is not running
  assert_count_restarts_R5: assert property (@(posedge clk) disable iff (rst)
    !run_i |=> (cnt == '0));

  assert_count_in_range_R4: assert property (@(posedge clk) disable iff (rst)
    32'(cnt) < LIMIT);
endmodule

// File: rtl/pws_cause_reg.sv
module pws_cause_reg #(
  parameter int W = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] set_i,
  input  logic         wr_i,
  input  logic [W-1:0] wdata_i,
  output logic [W-1:0] cause_o
);
  for (genvar k = 0; k < W; k++) begin : g_bit
    always_ff @(posedge clk) begin
      if (rst)               cause_o[k] <= 1'b0;
      else if (set_i[k])     cause_o[k] <= 1'b1;
      else if (wr_i && wdata_i[k]) cause_o[k] <= 1'b0;
    end

    assert_set_wins_R10: assert property (@(posedge clk) disable iff (rst)
      set_i[k] |=> cause_o[k]);

    assert_clear_works_R10: assert property (@(posedge clk) disable iff (rst)
      (wr_i && wdata_i[k] && !set_i[k]) |=> !cause_o[k]);

    assert_hold_value_R10: assert property (@(posedge clk) disable iff (rst)
      (!set_i[k] && !(wr_i && wdata_i[k])) |=> $stable(cause_o[k]));
  end
endmodule

// File: rtl/pwr_seq_ctrl.sv
module pwr_seq_ctrl
  import pwr_seq_pkg::*;
#(
  parameter int RS_TICKS = 4,
  parameter int DM_TICKS = 8,
  parameter int HOLD_CYC = 16,
  localparam int HW = $clog2(HOLD_CYC + 1)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               tick,
  input  logic               rstimer_clr,
  input  logic               dm_enable,
  input  logic               dm_clr,
  input  logic               hib_req,
  input  logic               irq_pending,
  input  logic               batt_runout,
  input  logic               batt_unlock,
  input  logic               cause_wr,
  input  logic [CAUSE_W-1:0] cause_wdata,
  output logic               periph_rst,
  output logic               cpu_cold_rst,
  output logic               cpu_clk_stop,
  output logic [CAUSE_W-1:0] cause
);
  seq_state_t        state, state_d;
  logic [HW-1:0]     hold_cnt;
  logic              rs_arm;
  logic              rs_exp, dm_exp;
  logic              in_run, restart, batt_evt, rst_evt;
  logic [CAUSE_W-1:0] cause_set;

  assign in_run   = (state == ST_RUN);
  assign batt_evt = batt_runout | batt_unlock;
  assign rst_evt  = rs_exp | dm_exp | batt_evt;

  pws_tick_window #(.LIMIT(RS_TICKS)) u_restart_win (
    .clk      (clk),
    .rst      (rst),
    .tick_i   (tick),
    .run_i    (rs_arm & in_run & ~rstimer_clr),
    .expire_o (rs_exp)
  );

  pws_tick_window #(.LIMIT(DM_TICKS)) u_deadman_win (
    .clk      (clk),
    .rst      (rst),
    .tick_i   (tick),
    .run_i    (dm_enable & in_run & ~dm_clr),
    .expire_o (dm_exp)
  );

  always_comb begin
    state_d = state;
    case (state)
      ST_RUN: begin
        if (rst_evt)                       state_d = ST_HOLD;
        else if (hib_req && !irq_pending)  state_d = ST_HIB;
      end
      ST_HOLD: begin
        if (32'(hold_cnt) >= HOLD_CYC - 1) state_d = ST_RUN;
      end
      ST_HIB: begin
        if (batt_evt)                      state_d = ST_HOLD;
        else if (irq_pending)              state_d = ST_RUN;
      end
      default:                             state_d = ST_RUN;
    endcase
  end

  assign restart = !in_run && (state_d == ST_RUN);

  always_comb begin
    cause_set = '0;
    cause_set[CAUSE_TIMEOUT] = rs_exp | (batt_runout & (state != ST_HOLD));
    cause_set[CAUSE_DEADMAN] = dm_exp;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state        <= ST_RUN;
      hold_cnt     <= '0;
      rs_arm       <= 1'b1;
      periph_rst   <= 1'b0;
      cpu_cold_rst <= 1'b0;
      cpu_clk_stop <= 1'b0;
    end else begin
      state        <= state_d;
      hold_cnt     <= (state == ST_HOLD && state_d == ST_HOLD) ? hold_cnt + 1'b1 : '0;
      if (restart)          rs_arm <= 1'b1;
      else if (rstimer_clr) rs_arm <= 1'b0;
      periph_rst   <= (state_d != ST_RUN);
      cpu_cold_rst <= (state_d == ST_HOLD);
      cpu_clk_stop <= (state_d == ST_HIB);
    end
  end

  pws_cause_reg #(.W(CAUSE_W)) u_cause (
    .clk     (clk),
    .rst     (rst),
    .set_i   (cause_set),
    .wr_i    (cause_wr),
    .wdata_i (cause_wdata),
    .cause_o (cause)
  );

  assert_cold_has_periph_R2: assert property (@(posedge clk) disable iff (rst)
    cpu_cold_rst |-> periph_rst);

  assert_hib_no_cold_R6: assert property (@(posedge clk) disable iff (rst)
    cpu_clk_stop |-> !cpu_cold_rst);

  assert_hib_gated_R7: assert property (@(posedge clk) disable iff (rst)
    (!cpu_clk_stop && !cpu_cold_rst && hib_req && irq_pending && !rst_evt) |=> !periph_rst);

  assert_release_rearms_R9: assert property (@(posedge clk) disable iff (rst)
    $fell(cpu_cold_rst) |-> rs_arm);

  assert_reset_beats_hib_R11: assert property (@(posedge clk) disable iff (rst)
    (in_run && rst_evt && hib_req) |=> (cpu_cold_rst && !cpu_clk_stop));
endmodule

// File: tb/pwr_seq_ctrl_tb_top.sv
module pwr_seq_ctrl_tb_top;
  localparam int RS_T = 4;
  localparam int DM_T = 6;
  localparam int HOLD = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic tick = 0, rstimer_clr = 0, dm_enable = 0, dm_clr = 0;
  logic hib_req = 0, irq_pending = 0, batt_runout = 0, batt_unlock = 0;
  logic cause_wr = 0;
  logic [1:0] cause_wdata = '0;
  logic periph_rst, cpu_cold_rst, cpu_clk_stop;
  logic [1:0] cause;
  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #4 clk = ~clk;

  pwr_seq_ctrl #(.RS_TICKS(RS_T), .DM_TICKS(DM_T), .HOLD_CYC(HOLD)) dut_i (
    .clk(clk), .rst(rst), .tick(tick), .rstimer_clr(rstimer_clr),
    .dm_enable(dm_enable), .dm_clr(dm_clr), .hib_req(hib_req),
    .irq_pending(irq_pending), .batt_runout(batt_runout), .batt_unlock(batt_unlock),
    .cause_wr(cause_wr), .cause_wdata(cause_wdata), .periph_rst(periph_rst),
    .cpu_cold_rst(cpu_cold_rst), .cpu_clk_stop(cpu_clk_stop), .cause(cause));

  // outputs packed as {periph_rst, cpu_cold_rst, cpu_clk_stop}
  function automatic logic [2:0] outs();
    return {periph_rst, cpu_cold_rst, cpu_clk_stop};
  endfunction

  task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic cyc();
    @(negedge clk);
  endtask

  task automatic tk();
    tick = 1; cyc(); tick = 0;
  endtask

  task automatic do_reset();
    rst = 1; cyc(); cyc(); rst = 0;
  endtask

  task automatic svc_restart();
    rstimer_clr = 1; cyc(); rstimer_clr = 0;
  endtask

  task automatic t_reset_and_restart_timer();
    rst = 1; cyc();
    chk("R1 outs in reset", 8'(outs()), 8'h0);
    cyc(); rst = 0; cyc();
    chk("R1 outs after reset", 8'(outs()), 8'h0);
    chk("R1 cause after reset", 8'(cause), 8'h0);
    for (int i = 0; i < RS_T - 1; i++) tk();
    chk("R2 no reset before limit", 8'(outs()), 8'h0);
    tk();
    chk("R2 reset on limit tick", 8'(outs()), 8'h6);
    chk("R2 timeout cause", 8'(cause), 8'h1);
    for (int i = 0; i < HOLD - 1; i++) cyc();
    chk("R9 still held at last hold cycle", 8'(outs()), 8'h6);
    cyc();
    chk("R9 released after hold", 8'(outs()), 8'h0);
    for (int i = 0; i < RS_T - 1; i++) tk();
    chk("R9 rearmed, not yet expired", 8'(outs()), 8'h0);
    cause_wr = 1; cause_wdata = 2'b01; tk(); cause_wr = 0;
    chk("R9 rearmed timer expires", 8'(outs()), 8'h6);
    chk("R10 set beats clear", 8'(cause), 8'h1);
    cause_wr = 1; cause_wdata = 2'b01; cyc(); cause_wr = 0;
    chk("R10 write one clears", 8'(cause), 8'h0);
  endtask

  task automatic t_service();
    logic [2:0] seen = '0;
    do_reset(); svc_restart();
    for (int i = 0; i < 3 * RS_T; i++) begin tk(); seen |= outs(); end
    chk("R3 serviced timer never fires", 8'(seen), 8'h0);
  endtask

  task automatic t_deadman();
    logic [2:0] seen = '0;
    do_reset(); svc_restart();
    for (int i = 0; i < 2 * DM_T; i++) begin tk(); seen |= outs(); end
    chk("R5 disabled deadman idle", 8'(seen), 8'h0);
    dm_enable = 1;
    for (int i = 0; i < DM_T - 1; i++) tk();
    chk("R5 before clear no reset", 8'(outs()), 8'h0);
    dm_clr = 1; cyc(); dm_clr = 0;
    for (int i = 0; i < DM_T - 1; i++) tk();
    chk("R5 clear restarted count", 8'(outs()), 8'h0);
    tk();
    chk("R4 deadman expiry resets", 8'(outs()), 8'h6);
    chk("R4 deadman cause", 8'(cause), 8'h2);
    dm_enable = 0;
    cause_wr = 1; cause_wdata = 2'b10; cyc(); cause_wr = 0;
    chk("R10 deadman bit cleared", 8'(cause), 8'h0);
  endtask

  task automatic t_hibernate();
    logic [2:0] seen = '0;
    do_reset(); svc_restart();
    irq_pending = 1; hib_req = 1; cyc(); hib_req = 0;
    chk("R7 hib with pending irq ignored", 8'(outs()), 8'h0);
    irq_pending = 0;
    batt_runout = 1; cyc(); batt_runout = 0;
    chk("R8 runout cause", 8'(cause), 8'h1);
    for (int i = 0; i < HOLD; i++) cyc();
    svc_restart();
    hib_req = 1; cyc(); hib_req = 0;
    chk("R6 hibernate outputs", 8'(outs()), 8'h5);
    for (int i = 0; i < 3 * RS_T; i++) begin tk(); seen |= outs(); end
    chk("R6 no cold reset in hibernate", 8'(seen), 8'h5);
    chk("R6 cause unchanged", 8'(cause), 8'h1);
    irq_pending = 1; cyc(); irq_pending = 0;
    chk("R6 wake releases", 8'(outs()), 8'h0);
    for (int i = 0; i < RS_T; i++) tk();
    chk("R9 wake rearms restart timer", 8'(outs()), 8'h6);
  endtask

  task automatic t_battery();
    do_reset(); svc_restart();
    batt_unlock = 1; cyc(); batt_unlock = 0;
    chk("R8 unlock resets", 8'(outs()), 8'h6);
    chk("R8 unlock sets no cause", 8'(cause), 8'h0);
    do_reset(); svc_restart();
    batt_runout = 1; cyc(); batt_runout = 0;
    chk("R8 runout resets", 8'(outs()), 8'h6);
    chk("R8 runout timeout cause", 8'(cause), 8'h1);
  endtask

  task automatic t_priority();
    do_reset(); svc_restart();
    hib_req = 1; batt_unlock = 1; cyc(); hib_req = 0; batt_unlock = 0;
    chk("R11 reset wins over hibernate", 8'(outs()), 8'h6);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    t_reset_and_restart_timer();
    t_service();
    t_deadman();
    t_hibernate();
    t_battery();
    t_priority();
    finish_run();
  end
endmodule